// File: doc/BRIEF.md
# Two-Symbol-per-Clock Precoding Equalizer

This block sits on the transmit side of a serial link and removes post-cursor intersymbol interference before symbols reach the channel. Each clock it takes a pair of symbols, an earlier (even) one and a later (odd) one. From each symbol it subtracts a weighted sum of the eight most recent precoded outputs. It then folds the difference back into a bounded window with a modulo operation. This makes it an IIR equalizer whose amplitude cannot grow. The receiver applies the matching modulo. The outputs are signed 6-bit samples meant for a DAC driver.

A mode input picks two-level or four-level signalling for each pair. The eight tap weights are loaded through a simple write port. To shorten the loop, the contribution of the older history taps is computed one clock ahead and held in registers. Only the one or two newest taps sit in the single-cycle feedback path. Inside each clock, the odd symbol's newest tap uses the even result from that same clock.

Top module: `thp_precoder`

## Requirements
- R1: Symbol codes are decoded per pair. In four-level mode, codes 00, 01, 10 and 11 mean levels -3, -1, +1 and +3. In two-level mode only bit 1 counts: 0 means -1 and 1 means +1. One output LSB is 1/8 of a unit level, so the levels appear as -24, -8, +8 and +24.
- R2: When all tap weights are zero, each output sample equals the scaled level of its own input symbol.
- R3: Each output is y[n] = wrap(x[n] - floor(S/32)), where S is the sum over j=1..8 of w_j*y[n-j]. The even symbol of a pair is earlier than the odd one, so the odd symbol's tap-1 term uses the even output of the same pair.
- R4: The wrap reduces a value modulo 64 into [-32,31] in four-level mode, and modulo 32 into [-16,15] in two-level mode.
- R5: A pair accepted with in_valid at a clock edge appears on out_even and out_odd right after that edge, with out_valid high. out_valid is low after any edge where in_valid was low.
- R6: Without in_valid, the outputs and the feedback history hold. A stream with idle gaps gives the same samples as the same stream without gaps.
- R7: Reset clears the tap weights, the feedback history, out_valid and both outputs to zero.
- R8: When cfg_we is high at an edge, cfg_wdata (signed 6-bit, worth value/32) is written to tap cfg_addr+1. Address 0 is the newest tap and address 7 is the oldest. A write applies to pairs presented two or more clocks after the write edge.
- R9: The mode is taken with each pair. The feedback history carries over when the mode changes between pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pam4 | input | 1 | 1 = four-level, 0 = two-level, for the current pair |
| in_valid | input | 1 | Qualifies the symbol pair |
| sym_even | input | 2 | Earlier symbol code of the pair |
| sym_odd | input | 2 | Later symbol code of the pair |
| cfg_we | input | 1 | Tap weight write enable |
| cfg_addr | input | 3 | Tap index minus one |
| cfg_wdata | input | 6 | Signed tap weight |
| out_valid | output | 1 | Precoded pair valid |
| out_even | output | 6 | Precoded earlier sample |
| out_odd | output | 6 | Precoded later sample |

## Verification
The assertions assume that in_valid, mode_pam4 and the symbol codes are settled at each rising edge, and that reset is the only thing that disturbs history between valid pairs. They also assume no weight write lands within two clocks of a pair that should use it. The bench follows these rules by driving every input on the falling edge. After each write it waits two idle clocks before sending symbols. It applies reset only with in_valid low.

// File: rtl/thp_precoder.sv
module thp_precoder #(
  parameter int NTAPS = 8,
  parameter int WW    = 6,
  parameter int DW    = 6,
  parameter int FRAC  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pam4,
  input  logic          in_valid,
  input  logic [1:0]    sym_even,
  input  logic [1:0]    sym_odd,
  input  logic          cfg_we,
  input  logic [$clog2(NTAPS)-1:0] cfg_addr,
  input  logic [WW-1:0] cfg_wdata,
  output logic          out_valid,
  output logic [DW-1:0] out_even,
  output logic [DW-1:0] out_odd
);
  localparam int AW   = $clog2(NTAPS);
  localparam int ACCW = WW + DW + AW + 1;
  localparam int LSH  = DW - 3;

  logic signed [WW-1:0]   wt   [NTAPS];
  logic signed [DW-1:0]   hist [NTAPS];
  logic signed [ACCW-1:0] pe_q, po_q, pe_d, po_d, fb_e, fb_o;
  logic signed [DW-1:0]   x_e, x_o, y_e, y_o;

  function automatic logic signed [DW-1:0] to_level(input logic [1:0] c, input logic pam4);
    int lv;
    if (pam4) lv = 2 * int'(c) - 3;
    else      lv = c[1] ? 1 : -1;
    return DW'(lv <<< LSH);
  endfunction

  function automatic logic signed [ACCW-1:0] mul(input logic signed [WW-1:0] w,
                                                 input logic signed [DW-1:0] h);
    return ACCW'(w) * ACCW'(h);
  endfunction

  function automatic logic signed [DW-1:0] wrap(input logic signed [ACCW-1:0] v, input logic pam4);
    return pam4 ? v[DW-1:0] : {v[DW-2], v[DW-2:0]};
  endfunction

  always_comb begin
    pe_d = '0;
    po_d = '0;
    for (int k = 2; k < NTAPS; k++)
      pe_d += mul(wt[k], in_valid ? hist[k-2] : hist[k]);
    for (int k = 3; k < NTAPS; k++)
      po_d += mul(wt[k], in_valid ? hist[k-3] : hist[k-1]);
  end

  assign x_e  = to_level(sym_even, mode_pam4);
  assign x_o  = to_level(sym_odd, mode_pam4);
  assign fb_e = pe_q + mul(wt[0], hist[0]) + mul(wt[1], hist[1]);
  assign y_e  = wrap(ACCW'(x_e) - (fb_e >>> FRAC), mode_pam4);
  assign fb_o = po_q + mul(wt[0], y_e) + mul(wt[1], hist[0]) + mul(wt[2], hist[1]);
  assign y_o  = wrap(ACCW'(x_o) - (fb_o >>> FRAC), mode_pam4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin
        wt[k]   <= '0;
        hist[k] <= '0;
      end
      pe_q      <= '0;
      po_q      <= '0;
      out_valid <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      if (cfg_we) wt[cfg_addr] <= cfg_wdata;
      pe_q      <= pe_d;
      po_q      <= po_d;
      out_valid <= in_valid;
      if (in_valid) begin
        hist[0]  <= y_o;
        hist[1]  <= y_e;
        for (int k = 2; k < NTAPS; k++) hist[k] <= hist[k-2];
        out_even <= y_e;
        out_odd  <= y_o;
      end
    end
  end
endmodule

// File: rtl/thp_precoder_chk.sv
module thp_precoder_chk #(
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_pam4,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_even,
  input logic [DW-1:0] out_odd
);
  localparam int HALF2 = 2 ** (DW - 2);

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_even) && $stable(out_odd)));

  // R4
  pam2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_pam4) |=>
      ($signed(out_even) >= -HALF2) && ($signed(out_even) < HALF2) &&
      ($signed(out_odd)  >= -HALF2) && ($signed(out_odd)  < HALF2));
endmodule

bind thp_precoder thp_precoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pam4(mode_pam4), .in_valid(in_valid),
  .out_valid(out_valid), .out_even(out_even), .out_odd(out_odd)
);

// File: tb/test_thp_precoder.sv
`timescale 1ns/1ps
module test_thp_precoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_pam4 = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] sym_even = '0, sym_odd = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic       out_valid;
  logic [5:0] out_even, out_odd;

  thp_precoder i_thp_precoder (
    .clk(clk), .rst_n(rst_n), .mode_pam4(mode_pam4), .in_valid(in_valid),
    .sym_even(sym_even), .sym_odd(sym_odd), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_even(out_even), .out_odd(out_odd)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  int w [8];
  int yh [8];
  int last_e = 0, last_o = 0;
  logic [15:0] lf = 16'hACE1;

  // entry: {mode, sym_even, sym_odd, exp_even, exp_odd}
  localparam logic [16:0] PT [8] = '{
    {1'b1, 2'b00, 2'b11, 6'(-24), 6'(24)},
    {1'b1, 2'b01, 2'b10, 6'(-8),  6'(8)},
    {1'b1, 2'b11, 2'b00, 6'(24),  6'(-24)},
    {1'b1, 2'b10, 2'b01, 6'(8),   6'(-8)},
    {1'b0, 2'b00, 2'b10, 6'(-8),  6'(8)},
    {1'b0, 2'b11, 2'b01, 6'(8),   6'(-8)},
    {1'b0, 2'b01, 2'b11, 6'(-8),  6'(8)},
    {1'b0, 2'b10, 2'b00, 6'(8),   6'(-8)}
  };

  task automatic check_eq(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(logic [1:0] c, logic m);
    if (m) return (2 * int'(c) - 3) * 8;
    return c[1] ? 8 : -8;
  endfunction

  function automatic int wrapm(int v, logic m);
    int mm = m ? 64 : 32;
    return ((v + mm / 2) % mm + mm) % mm - mm / 2;
  endfunction

  task automatic model_sym(int x, logic m, output int y);
    int acc = 0;
    for (int j = 0; j < 8; j++) acc += w[j] * yh[j];
    y = wrapm(x - (acc >>> 5), m);
    for (int j = 7; j > 0; j--) yh[j] = yh[j-1];
    yh[0] = y;
  endtask

  task automatic step(logic v, logic m, logic [1:0] se, logic [1:0] so, string req);
    int ee, eo;
    @(negedge clk);
    in_valid = v; mode_pam4 = m; sym_even = se; sym_odd = so;
    if (v) begin
      model_sym(lvl(se, m), m, ee);
      model_sym(lvl(so, m), m, eo);
      last_e = ee; last_o = eo;
    end
    @(posedge clk); #1;
    if (v) begin
      check_eq("R5", "out_valid", int'(out_valid), 1);
      check_eq(req, "out_even", $signed(out_even), ee);
      check_eq(req, "out_odd", $signed(out_odd), eo);
    end else begin
      check_eq("R5", "out_valid idle", int'(out_valid), 0);
      check_eq("R6", "hold even", $signed(out_even), last_e);
      check_eq("R6", "hold odd", $signed(out_odd), last_o);
    end
  endtask

  task automatic wr_tap(int idx, int val);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = 6'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    w[idx] = val;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R7", "reset out_valid", int'(out_valid), 0);
    check_eq("R7", "reset out_even", $signed(out_even), 0);
    check_eq("R7", "reset out_odd", $signed(out_odd), 0);
    rst_n = 1'b1;
    for (int j = 0; j < 8; j++) begin w[j] = 0; yh[j] = 0; end
    last_e = 0; last_o = 0;
  endtask

  function automatic logic [1:0] rnd2();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[1:0];
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(4 * 100000);
    nchk++; nerr++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] a, b;
    for (int j = 0; j < 8; j++) begin w[j] = 0; yh[j] = 0; end
    do_reset();

    // R1 R2: passthrough table with zero weights
    for (int i = 0; i < 8; i++) begin
      step(1'b1, PT[i][16], PT[i][15:14], PT[i][13:12], "R2");
      check_eq("R1", "table even", $signed(out_even), $signed(PT[i][11:6]));
      check_eq("R1", "table odd", $signed(out_odd), $signed(PT[i][5:0]));
    end
    step(1'b0, 1'b1, 2'b00, 2'b00, "R6");

    // R3: tap 1 only, odd uses same-clock even result
    do_reset();
    wr_tap(0, 16);
    step(1'b1, 1'b1, 2'b11, 2'b00, "R3");
    check_eq("R3", "odd from even", $signed(out_odd), 28);

    // R8: write only the oldest tap
    do_reset();
    wr_tap(7, 16);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, rnd2(), rnd2(), "R8");

    // R3: full weight set, four-level stream
    wr_tap(0, 16); wr_tap(1, -8); wr_tap(2, 4); wr_tap(6, 2); wr_tap(7, -1);
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, rnd2(), rnd2(), "R3");

    // R6 R9: gaps and mode changes per pair
    for (int i = 0; i < 12; i++) begin
      a = rnd2(); b = rnd2();
      step(1'b1, 1'(i % 3 == 0), a, b, "R9");
      step(1'b0, 1'b0, b, a, "R6");
    end

    // R4: extreme weights, both modes
    for (int j = 0; j < 8; j++) wr_tap(j, (j % 2 == 0) ? -32 : 31);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, rnd2(), rnd2(), "R4");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, rnd2(), rnd2(), "R4");

    // R7 R4: reset mid-stream clears history, then a known wrap
    do_reset();
    wr_tap(0, -32);
    step(1'b1, 1'b1, 2'b11, 2'b11, "R4");
    check_eq("R4", "wrap even", $signed(out_even), 24);
    check_eq("R4", "wrap odd", $signed(out_odd), -16);
    step(1'b1, 1'b1, 2'b11, 2'b11, "R4");

    @(negedge clk);
    in_valid = 1'b0;
    summary();
    $finish;
  end
endmodule